// File: doc/BRIEF.md
# Three-Level Nesting Interrupt Arbiter

This block sits between a set of interrupt-raising peripherals and a processor core. Each source has a sticky flag that a one-cycle set pulse raises and that software clears. Each source also has an enable bit. The sources are grouped onto ten vectors. A vector asks for service when any of its enabled flags is set.

Every vector is ranked low or high. The first vectors may also be raised to a top level above high. The arbiter picks the best pending vector whose rank is strictly above the rank now in service. It presents that vector's entry address and rank to the core.

When the core accepts the request, the accepted rank is pushed onto a small nesting stack. It then becomes the rank in service. A return pops the stack and restores the rank that was interrupted. The outputs are registered, so they follow the flags, enables and rank settings one clock later.

Top module: `irq_nest_arbiter`

## Requirements
- R1: After reset, `irq_req` is 0, `cur_lvl` is 0 (nothing in service) and every source flag is clear.
- R2: Ranks are encoded as 0 none, 1 low, 2 high and 3 top. A vector produces a request only when its rank is strictly greater than `cur_lvl`. A vector of equal or lower rank stays pending without a request.
- R3: For vector v below `NUM_TOP_VEC` (vectors 0 and 1 by default), `vec_top[v]`=1 gives rank 3 and the vector's `vec_hi` bit is ignored. For all other vectors `vec_top` has no effect, and the rank is 2 when `vec_hi[v]`=1, else 1.
- R4: When pending vectors have different ranks, the one with the greatest rank wins.
- R5: When pending vectors share the winning rank, the one with the smallest index, and therefore the smallest address, wins.
- R6: An `irq_ack` while `irq_req`=1 pushes `irq_lvl` onto the nesting stack. `cur_lvl` shows the pushed rank from the next cycle on. Three nested acceptances (ranks 1, 2, 3) fit.
- R7: An `irq_ret` pops the stack and restores the previous rank, or 0 when the stack empties. A return on an empty stack is ignored. A return in the same cycle as an accepted `irq_ack` is ignored.
- R8: `irq_req`, `irq_addr` and `irq_lvl` are registered one clock after the flags and settings they reflect. In the cycle after an accepted acknowledge, `irq_req` is 0 and `irq_lvl` is 0. An `irq_ack` while `irq_req`=0 is ignored.
- R9: Sources are assigned to vectors in ascending order, with per-vector counts 1,1,3,4,2,3,3,3,3,4. Vector 0 is source 0, vector 2 is sources 2-4 and vector 9 is sources 23-26. A vector is pending when the OR of its flags ANDed with `src_en` is 1. Disabled flags do not request.
- R10: A source flag stays set until its `src_clr` bit is 1. When `src_set` and `src_clr` hit the same bit in one cycle, the flag ends set.
- R11: `irq_addr` is 3 + 8 × vector index, which runs from 0x03 for vector 0 to 0x4B for vector 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | NUM_SRC | One-cycle pulses that raise source flags |
| src_clr | input | NUM_SRC | Software clear of source flags |
| src_en | input | NUM_SRC | Per-source enable |
| vec_hi | input | NUM_VEC | Rank high (1) or low (0) per vector |
| vec_top | input | NUM_TOP_VEC | Top-rank select for the first vectors |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_ret | input | 1 | Core finishes the service in progress |
| irq_req | output | 1 | Request to the core |
| irq_addr | output | ADDR_W | Entry address of the winning vector |
| irq_lvl | output | 2 | Rank of the presented request |
| cur_lvl | output | 2 | Rank now in service (top of nesting stack) |

## Verification
The hardest state to reach from the ports is a full stack three deep, followed by returns that unwind it. The stimulus raises a low-ranked source and accepts it. It then raises a high-ranked and a top-ranked source and accepts each one. While a low service is active, a second low source is raised to show that equal rank does not request. All flags are then cleared and four returns are issued, the last one on an empty stack. Same-cycle accept-plus-return and set-plus-clear are driven on purpose. The rank and tie-break cases are walked from a vector table.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   typedef enum logic [1:0] {
      LVL_NONE = 2'd0,
      LVL_LOW  = 2'd1,
      LVL_HIGH = 2'd2,
      LVL_TOP  = 2'd3
   } lvl_e;

   localparam int unsigned LVL_W = 2;

endpackage

// File: rtl/irq_src_collect.sv
module irq_src_collect #(
   parameter int unsigned NUM_SRC = 27,
   parameter int unsigned NUM_VEC = 10,
   parameter int unsigned SRC_PER_VEC [NUM_VEC] = '{1, 1, 3, 4, 2, 3, 3, 3, 3, 4}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_set,
   input  logic [NUM_SRC-1:0] src_clr,
   input  logic [NUM_SRC-1:0] src_en,
   output logic [NUM_VEC-1:0] vec_pend
);

   function automatic int unsigned first_of(int unsigned v);
      int unsigned s = 0;
      for (int unsigned i = 0; i < v; i++) s += SRC_PER_VEC[i];
      return s;
   endfunction

   localparam int unsigned SRC_TOTAL = first_of(NUM_VEC);

   generate
      if (SRC_TOTAL != NUM_SRC) begin : g_bad_map
         $error("source-to-vector counts do not add up to NUM_SRC");
      end
   endgenerate

   logic [NUM_SRC-1:0] flag_q;
   logic [NUM_SRC-1:0] live;

   // set has priority over clear so that no event is lost
   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~src_clr) | src_set;
   end

   assign live = flag_q & src_en;

   generate
      for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
         localparam int unsigned LO  = first_of(v);
         localparam int unsigned CNT = SRC_PER_VEC[v];
         if (CNT == 0) begin : g_empty
            $error("each vector needs at least one source");
         end
         assign vec_pend[v] = |live[LO +: CNT];
      end
   endgenerate

   // R10: a flag never drops without a clear
   p_flag_sticky_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(flag_q) & ~$past(src_clr)) & ~flag_q) == '0));

   // R10: a set bit is present on the following cycle even with a clear
   p_set_wins_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_q & $past(src_set)) == $past(src_set)));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
   import irq_arb_pkg::*;
#(
   parameter int unsigned NUM_VEC     = 10,
   parameter int unsigned NUM_TOP_VEC = 2,
   localparam int unsigned IDX_W      = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic [NUM_VEC-1:0]     vec_pend,
   input  logic [NUM_VEC-1:0]     vec_hi,
   input  logic [NUM_TOP_VEC-1:0] vec_top,
   input  lvl_e                   cur_lvl,
   output logic                   win_vld,
   output logic [IDX_W-1:0]       win_idx,
   output lvl_e                   win_lvl
);

   lvl_e vlvl [NUM_VEC];

   generate
      for (genvar v = 0; v < NUM_VEC; v++) begin : g_rank
         if (v < NUM_TOP_VEC) begin : g_top_capable
            assign vlvl[v] = vec_top[v] ? LVL_TOP : (vec_hi[v] ? LVL_HIGH : LVL_LOW);
         end else begin : g_plain
            assign vlvl[v] = vec_hi[v] ? LVL_HIGH : LVL_LOW;
         end
      end
   endgenerate

   // scan from the top index down so that, at equal rank, the lowest index is kept last
   always_comb begin
      win_vld = 1'b0;
      win_idx = '0;
      win_lvl = LVL_NONE;
      for (int v = NUM_VEC - 1; v >= 0; v--) begin
         if (vec_pend[v] && (vlvl[v] > cur_lvl) && (vlvl[v] >= win_lvl)) begin
            win_vld = 1'b1;
            win_idx = IDX_W'(v);
            win_lvl = vlvl[v];
         end
      end
   end

   // R2: any winner must outrank the level in service
   always_comb begin
      if (win_vld) a_win_above_r2 : assert (win_lvl > cur_lvl);
   end

endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
   import irq_arb_pkg::*;
#(
   parameter int unsigned DEPTH = 3,
   localparam int unsigned SP_W = $clog2(DEPTH + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  lvl_e push_lvl,
   input  logic pop,
   output lvl_e cur_lvl
);

   generate
      if (DEPTH < 3) begin : g_bad_depth
         $error("stack must hold one entry per non-zero rank");
      end
   endgenerate

   lvl_e            stk_q [DEPTH];
   logic [SP_W-1:0] sp_q;
   logic            do_push;
   logic            do_pop;

   assign do_push = push && (sp_q < SP_W'(DEPTH));
   assign do_pop  = pop && !push && (sp_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q <= '0;
         for (int i = 0; i < DEPTH; i++) stk_q[i] <= LVL_NONE;
      end else if (do_push) begin
         stk_q[sp_q] <= push_lvl;
         sp_q        <= sp_q + SP_W'(1);
      end else if (do_pop) begin
         sp_q <= sp_q - SP_W'(1);
      end
   end

   assign cur_lvl = (sp_q == '0) ? LVL_NONE : stk_q[sp_q - SP_W'(1)];

   p_no_overflow_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (sp_q < SP_W'(DEPTH)));

   p_push_raises_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      do_push |=> (cur_lvl == $past(push_lvl)));

   p_empty_ret_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && (sp_q == '0)) |=> (sp_q == '0));

endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter
   import irq_arb_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 27,
   parameter int unsigned NUM_VEC     = 10,
   parameter int unsigned NUM_TOP_VEC = 2,
   parameter int unsigned SRC_PER_VEC [NUM_VEC] = '{1, 1, 3, 4, 2, 3, 3, 3, 3, 4},
   parameter int unsigned STACK_DEPTH = 3,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned VEC_BASE    = 3,
   parameter int unsigned VEC_STRIDE  = 8,
   localparam int unsigned IDX_W      = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_SRC-1:0]     src_set,
   input  logic [NUM_SRC-1:0]     src_clr,
   input  logic [NUM_SRC-1:0]     src_en,
   input  logic [NUM_VEC-1:0]     vec_hi,
   input  logic [NUM_TOP_VEC-1:0] vec_top,
   input  logic                   irq_ack,
   input  logic                   irq_ret,
   output logic                   irq_req,
   output logic [ADDR_W-1:0]      irq_addr,
   output logic [1:0]             irq_lvl,
   output logic [1:0]             cur_lvl
);

   generate
      if (NUM_TOP_VEC < 1 || NUM_TOP_VEC > NUM_VEC) begin : g_bad_top
         $error("NUM_TOP_VEC must lie in 1..NUM_VEC");
      end
      if (VEC_BASE + (NUM_VEC - 1) * VEC_STRIDE >= (1 << ADDR_W)) begin : g_bad_addr
         $error("vector addresses do not fit ADDR_W");
      end
   endgenerate

   logic [NUM_VEC-1:0] vec_pend;
   logic               win_vld;
   logic [IDX_W-1:0]   win_idx;
   lvl_e               win_lvl;
   lvl_e               svc_lvl;
   logic               accept;

   logic               req_q;
   logic [IDX_W-1:0]   idx_q;
   lvl_e               lvl_q;

   irq_src_collect #(
      .NUM_SRC     (NUM_SRC),
      .NUM_VEC     (NUM_VEC),
      .SRC_PER_VEC (SRC_PER_VEC)
   ) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_set  (src_set),
      .src_clr  (src_clr),
      .src_en   (src_en),
      .vec_pend (vec_pend)
   );

   irq_prio_pick #(
      .NUM_VEC     (NUM_VEC),
      .NUM_TOP_VEC (NUM_TOP_VEC)
   ) u_pick (
      .vec_pend (vec_pend),
      .vec_hi   (vec_hi),
      .vec_top  (vec_top),
      .cur_lvl  (svc_lvl),
      .win_vld  (win_vld),
      .win_idx  (win_idx),
      .win_lvl  (win_lvl)
   );

   assign accept = irq_ack && req_q;

   irq_lvl_stack #(
      .DEPTH (STACK_DEPTH)
   ) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (accept),
      .push_lvl (lvl_q),
      .pop      (irq_ret),
      .cur_lvl  (svc_lvl)
   );

   // the cycle after an accept is blanked so a stale winner cannot be taken twice
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         idx_q <= '0;
         lvl_q <= LVL_NONE;
      end else begin
         req_q <= win_vld && !accept;
         idx_q <= win_idx;
         lvl_q <= (win_vld && !accept) ? win_lvl : LVL_NONE;
      end
   end

   assign irq_req  = req_q;
   assign irq_lvl  = lvl_q;
   assign cur_lvl  = svc_lvl;
   assign irq_addr = ADDR_W'(VEC_BASE) + ADDR_W'(idx_q) * ADDR_W'(VEC_STRIDE);

   p_req_above_cur_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (lvl_q > svc_lvl));

   p_top_only_first_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && lvl_q == LVL_TOP) |-> (int'(idx_q) < int'(NUM_TOP_VEC)));

   p_ack_drops_req_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !irq_req);

   p_idle_lvl_none_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (lvl_q == LVL_NONE));

endmodule

// File: tb/tb_irq_nest_arbiter.sv
`timescale 1ns/100ps
module tb_irq_nest_arbiter;

   localparam int NS = 27;
   localparam int NV = 10;
   localparam logic [NS-1:0] ALL = '1;

   typedef struct packed {
      logic [NS-1:0] set;
      logic [NS-1:0] en;
      logic [NV-1:0] hi;
      logic [1:0]    top;
      logic          req;
      logic [3:0]    idx;
      logic [1:0]    lvl;
   } row_t;

   // rank and tie-break table, all with nothing in service
   localparam row_t ROWS [11] = '{
      '{(27'd1 << 26),                ALL,                 10'h000, 2'b00, 1'b1, 4'd9, 2'd1}, // R9 single low
      '{(27'd1 << 26) | (27'd1 << 20), ALL,                 10'h000, 2'b00, 1'b1, 4'd8, 2'd1}, // R5 tie
      '{(27'd1 << 26) | (27'd1 << 20), ALL,                 10'h200, 2'b00, 1'b1, 4'd9, 2'd2}, // R4 rank beats index
      '{(27'd1 << 0)  | (27'd1 << 14), ALL,                 10'h3FF, 2'b00, 1'b1, 4'd0, 2'd2}, // R5 tie at high
      '{(27'd1 << 0)  | (27'd1 << 1),  ALL,                 10'h3FF, 2'b10, 1'b1, 4'd1, 2'd3}, // R3 top beats high
      '{(27'd1 << 3)  | (27'd1 << 10), ALL & ~(27'd1 << 3), 10'h000, 2'b00, 1'b1, 4'd4, 2'd1}, // R9 masked source
      '{(27'd1 << 3),                 ALL & ~(27'd1 << 3), 10'h000, 2'b00, 1'b0, 4'd0, 2'd0}, // R9 all masked
      '{(27'd1 << 0)  | (27'd1 << 1),  ALL,                 10'h000, 2'b11, 1'b1, 4'd0, 2'd3}, // R5 tie at top
      '{(27'd1 << 6)  | (27'd1 << 25), ALL,                 10'h3FF, 2'b01, 1'b1, 4'd3, 2'd2}, // R3 top bit no effect
      '{(27'd1 << 0),                 ALL,                 10'h000, 2'b01, 1'b1, 4'd0, 2'd3}, // R3 hi ignored
      '{(27'd1 << 2)  | (27'd1 << 4),  (27'd1 << 4),        10'h000, 2'b00, 1'b1, 4'd2, 2'd1}  // R9 OR in group
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NS-1:0] src_set, src_clr, src_en;
   logic [NV-1:0] vec_hi;
   logic [1:0]    vec_top;
   logic          irq_ack, irq_ret;
   logic          irq_req;
   logic [7:0]    irq_addr;
   logic [1:0]    irq_lvl, cur_lvl;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   irq_nest_arbiter dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_set  (src_set),
      .src_clr  (src_clr),
      .src_en   (src_en),
      .vec_hi   (vec_hi),
      .vec_top  (vec_top),
      .irq_ack  (irq_ack),
      .irq_ret  (irq_ret),
      .irq_req  (irq_req),
      .irq_addr (irq_addr),
      .irq_lvl  (irq_lvl),
      .cur_lvl  (cur_lvl)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic pulse_set(input logic [NS-1:0] m);
      src_set = m;
      tick();
      src_set = '0;
   endtask

   task automatic clear_all();
      src_clr = ALL;
      tick();
      src_clr = '0;
   endtask

   task automatic do_ack();
      irq_ack = 1'b1;
      tick();
      irq_ack = 1'b0;
   endtask

   task automatic do_ret();
      irq_ret = 1'b1;
      tick();
      irq_ret = 1'b0;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog: got 1 expected 0 (run did not end)");
      summary();
   end

   initial begin
      int first;
      int cnt [NV] = '{1, 1, 3, 4, 2, 3, 3, 3, 3, 4};
      rst_n = 1'b0; src_set = '0; src_clr = '0; src_en = '0;
      vec_hi = '0; vec_top = '0; irq_ack = 1'b0; irq_ret = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1 reset state
      chk("R1 req after reset", 32'(irq_req), 0);
      chk("R1 cur_lvl after reset", 32'(cur_lvl), 0);
      src_en = ALL;
      tick();
      chk("R1 flags clear after reset", 32'(irq_req), 0);

      // table walk
      for (int i = 0; i < 11; i++) begin
         clear_all();
         src_en = ROWS[i].en; vec_hi = ROWS[i].hi; vec_top = ROWS[i].top;
         pulse_set(ROWS[i].set);
         tick();
         chk($sformatf("R4/R5/R3/R9 row %0d req", i), 32'(irq_req), 32'(ROWS[i].req));
         chk($sformatf("R4/R5/R3/R9 row %0d lvl", i), 32'(irq_lvl), 32'(ROWS[i].lvl));
         if (ROWS[i].req)
            chk($sformatf("R4/R5/R3/R9 row %0d addr", i), 32'(irq_addr), 32'(3 + 8 * ROWS[i].idx));
      end

      // R11 address of every vector
      src_en = ALL; vec_hi = '0; vec_top = '0;
      first = 0;
      for (int v = 0; v < NV; v++) begin
         clear_all();
         pulse_set(27'd1 << first);
         tick();
         chk($sformatf("R11 addr vec %0d", v), 32'(irq_addr), 32'(3 + 8 * v));
         first += cnt[v];
      end

      // nesting to full depth
      clear_all();
      vec_hi = 10'h020; vec_top = 2'b01;
      tick();
      pulse_set(27'd1 << 26);
      tick();
      chk("R8 req one cycle after pending", 32'(irq_req), 1);
      do_ack();
      chk("R6 cur_lvl low after ack", 32'(cur_lvl), 1);
      chk("R8 req blanked after ack", 32'(irq_req), 0);
      tick();
      chk("R2 same vector not re-requested", 32'(irq_req), 0);
      pulse_set(27'd1 << 20);
      tick();
      chk("R2 equal rank blocked", 32'(irq_req), 0);
      pulse_set(27'd1 << 11);
      tick();
      chk("R2 higher rank requests", 32'(irq_lvl), 2);
      chk("R4 high vector addr", 32'(irq_addr), 32'h2B);
      do_ack();
      chk("R6 cur_lvl high after ack", 32'(cur_lvl), 2);
      pulse_set(27'd1 << 0);
      tick();
      chk("R3 top rank request", 32'(irq_lvl), 3);
      do_ack();
      chk("R6 cur_lvl top at depth three", 32'(cur_lvl), 3);
      clear_all();
      tick();
      do_ret();
      chk("R7 first return", 32'(cur_lvl), 2);
      do_ret();
      chk("R7 second return", 32'(cur_lvl), 1);
      do_ret();
      chk("R7 third return", 32'(cur_lvl), 0);
      do_ret();
      chk("R7 return on empty stack", 32'(cur_lvl), 0);
      do_ack();
      chk("R8 ack without request ignored", 32'(cur_lvl), 0);

      // ack and return in one cycle
      pulse_set(27'd1 << 26);
      tick();
      do_ack();
      pulse_set(27'd1 << 11);
      tick();
      chk("R7 high request before combined", 32'(irq_req), 1);
      irq_ack = 1'b1; irq_ret = 1'b1;
      tick();
      irq_ack = 1'b0; irq_ret = 1'b0;
      chk("R7 return ignored with ack", 32'(cur_lvl), 2);
      clear_all();
      do_ret();
      chk("R7 unwind after combined", 32'(cur_lvl), 1);
      do_ret();
      tick();

      // sticky flags and set-vs-clear
      src_set = 27'd1 << 26; src_clr = 27'd1 << 26;
      tick();
      src_set = '0; src_clr = '0;
      tick();
      chk("R10 set wins over clear", 32'(irq_req), 1);
      repeat (4) tick();
      chk("R10 flag stays set", 32'(irq_req), 1);
      src_clr = 27'd1 << 26;
      tick();
      src_clr = '0;
      tick();
      chk("R10 cleared flag drops request", 32'(irq_req), 0);
      chk("R10 no level when idle", 32'(irq_lvl), 0);

      summary();
   end

endmodule